// File: doc/BRIEF.md
# DS1 Test Pattern Generator

This block produces a serial DS1 test stream, one unipolar NRZ bit for each clock on which the bit enable is high. The payload comes from one of several sources: three pseudo-random sequences of different lengths, a quasi-random variant with limited zero runs, fixed alternating, all-ones and all-zeros patterns, and a programmable 32-bit word. The source is chosen by a 3-bit select. A transmit-invert control complements every bit sent. A launch-edge control decides whether the outputs change on the rising or the falling clock edge.

In framed mode the block puts a framing bit in front of every 192 payload bits, which gives 193-bit frames. The framing bits follow the 12-frame superframe pattern or the 24-frame extended superframe sync pattern. A test control complements the framing bit of the twelfth frame, so that a downstream framer sees a deliberate framing error. Two marker outputs flag each framing bit and the first frame of each superframe. Line coding into bipolar form is handled elsewhere.

Top module: `ds1_tpgen`

## Requirements
- R1: Selects 000, 001 and 011 send the sequences of x^15+x^14+1, x^20+x^3+1 and x^23+x^18+1. Each starts from an all-ones state, so for degree N and middle tap T the payload bits are s[k]=1 for k<N and s[k]=s[k-N]^s[k-T] after that.
- R2: Select 010 sends the degree-20 sequence of R1. A bit is forced to 1 whenever that raw bit and the next 14 raw bits are all zero, so the output never holds more than 14 zeros in a row.
- R3: Select 100 sends 1,0,1,0,... beginning with 1. Select 101 sends all ones. Select 110 sends all zeros.
- R4: Select 111 repeats the 32-bit user word, most significant bit first.
- R5: When transmit invert is set, every bit on tx_data is complemented, framing bits included.
- R6: When launch select is 1, the outputs change on the rising clock edge. When it is 0, the same values appear at the following falling edge.
- R7: A clock with bit_en low advances nothing. tx_data holds its value and both markers are low.
- R8: In framed mode each frame is one framing bit followed by 192 payload bits. The payload source is paused during the framing bit, and frame 1 starts with the first enabled bit after reset.
- R9: With extended mode clear, the framing bits of frames 1 to 12 are 1,0,0,0,1,1,0,1,1,1,0,0.
- R10: With extended mode set, frames 4, 8, 12, 16, 20 and 24 carry the sync bits 0,0,1,0,1,1 in that order. All other framing bits of the 24-frame superframe are 1.
- R11: When frame-bit invert is set, the framing bit of the 12th frame of every superframe is complemented.
- R12: tx_frame_start is high alongside each framing bit, and tx_sf_start is high alongside the framing bit of frame 1. In unframed mode both stay low.
- R13: While rst_n is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Send one bit on this clock |
| cfg_pat_sel | input | 3 | Payload source select |
| cfg_tx_inv | input | 1 | Complement the transmitted data |
| cfg_launch_rise | input | 1 | 1: launch on rising edge, 0: falling edge |
| cfg_framed | input | 1 | Insert framing bits |
| cfg_esf | input | 1 | Extended 24-frame superframe instead of 12-frame |
| cfg_fbit_inv | input | 1 | Complement the 12th-frame framing bit |
| cfg_user_word | input | USER_W | Programmable repeating word |
| tx_data | output | 1 | Serial NRZ test data |
| tx_frame_start | output | 1 | Marks a framing bit |
| tx_sf_start | output | 1 | Marks the framing bit of frame 1 |

## Verification
The bit chosen on an enabled clock appears on tx_data and the markers one register later when the rising-edge launch is selected. With the falling-edge launch it appears half a cycle after that. The bench drives each input one nanosecond after a rising edge and samples one nanosecond after the next one. At that point a rising-launch result is due for the current edge, while a falling-launch output still shows the previous edge's value, and the reference model keeps both. Pattern, framing and marker values come from a behavioural model with its own sequence tables and frame arithmetic. It is compared on every clock, including clocks with bit_en low.

// File: rtl/ds1_tpg_pkg.sv
package ds1_tpg_pkg;

  typedef enum logic [2:0] {
    PAT_PRBS15 = 3'd0,
    PAT_PRBS20 = 3'd1,
    PAT_QRSS   = 3'd2,
    PAT_PRBS23 = 3'd3,
    PAT_ALT    = 3'd4,
    PAT_ONES   = 3'd5,
    PAT_ZEROS  = 3'd6,
    PAT_USER   = 3'd7
  } pat_sel_e;

  localparam int FRAME_BITS = 193;
  localparam int SF_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int FR_W       = $clog2(ESF_FRAMES);

  // framing bit of a 12-frame superframe, frame index 0..11
  function automatic logic sf_fbit(input logic [FR_W-1:0] f);
    logic [11:0] seq;
    seq = 12'b1000_1101_1100;
    if (f < FR_W'(SF_FRAMES)) return seq[4'd11 - f[3:0]];
    return 1'b1;
  endfunction

  // framing bit of a 24-frame superframe, frame index 0..23
  function automatic logic esf_fbit(input logic [FR_W-1:0] f);
    logic [FR_W-1:0] n;
    n = f + FR_W'(1);
    case (n)
      FR_W'(4), FR_W'(8), FR_W'(16): return 1'b0;
      FR_W'(12), FR_W'(20), FR_W'(24): return 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  // quasi-random bit: current output plus the next 14 all zero forces a one
  function automatic logic qrss_bit(input logic [19:0] s);
    return s[19] | (s[19:5] == 15'd0);
  endfunction

endpackage

// File: rtl/ds1_lfsr.sv
module ds1_lfsr #(
  parameter int N = 15,
  parameter int T = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [N-1:0] state
);
  logic fb;
  assign fb = state[N-1] ^ state[T-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                state <= '1;
    else if (state == '0)      state <= '1;
    else if (step)             state <= {state[N-2:0], fb};
  end
endmodule

// File: rtl/ds1_pat_src.sv
module ds1_pat_src
  import ds1_tpg_pkg::*;
#(
  parameter int USER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [2:0]        sel,
  input  logic [USER_W-1:0] user_word,
  output logic              pat_bit
);
  localparam int UIDX_W = $clog2(USER_W);

  logic [14:0]       s15;
  logic [19:0]       s20;
  logic [22:0]       s23;
  logic              alt_q;
  logic [UIDX_W-1:0] uidx;
  logic [USER_W-1:0] ushift;

  ds1_lfsr #(.N(15), .T(14)) u_p15 (.clk(clk), .rst_n(rst_n), .step(step), .state(s15));
  ds1_lfsr #(.N(20), .T(3))  u_p20 (.clk(clk), .rst_n(rst_n), .step(step), .state(s20));
  ds1_lfsr #(.N(23), .T(18)) u_p23 (.clk(clk), .rst_n(rst_n), .step(step), .state(s23));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= 1'b1;
      uidx  <= '0;
    end else if (step) begin
      alt_q <= ~alt_q;
      uidx  <= (uidx == UIDX_W'(USER_W-1)) ? '0 : uidx + UIDX_W'(1);
    end
  end

  assign ushift = user_word << uidx;

  always_comb begin
    case (pat_sel_e'(sel))
      PAT_PRBS15: pat_bit = s15[14];
      PAT_PRBS20: pat_bit = s20[19];
      PAT_QRSS:   pat_bit = qrss_bit(s20);
      PAT_PRBS23: pat_bit = s23[22];
      PAT_ALT:    pat_bit = alt_q;
      PAT_ONES:   pat_bit = 1'b1;
      PAT_ZEROS:  pat_bit = 1'b0;
      default:    pat_bit = ushift[USER_W-1];
    endcase
  end
endmodule

// File: rtl/ds1_frame_ctr.sv
module ds1_frame_ctr
  import ds1_tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             esf,
  output logic [POS_W-1:0] bit_pos,
  output logic [FR_W-1:0]  frame_idx,
  output logic             is_fbit
);
  logic [FR_W-1:0] last_fr;
  assign last_fr = esf ? FR_W'(ESF_FRAMES-1) : FR_W'(SF_FRAMES-1);
  assign is_fbit = (bit_pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos   <= '0;
      frame_idx <= '0;
    end else if (adv) begin
      if (bit_pos == POS_W'(FRAME_BITS-1)) begin
        bit_pos   <= '0;
        frame_idx <= (frame_idx >= last_fr) ? '0 : frame_idx + FR_W'(1);
      end else begin
        bit_pos <= bit_pos + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/ds1_tpgen.sv
module ds1_tpgen
  import ds1_tpg_pkg::*;
#(
  parameter int USER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [2:0]        cfg_pat_sel,
  input  logic              cfg_tx_inv,
  input  logic              cfg_launch_rise,
  input  logic              cfg_framed,
  input  logic              cfg_esf,
  input  logic              cfg_fbit_inv,
  input  logic [USER_W-1:0] cfg_user_word,
  output logic              tx_data,
  output logic              tx_frame_start,
  output logic              tx_sf_start
);
  // named internal events, also watched by the bound checker
  logic             step;
  logic             adv;
  logic             pat_bit;
  logic [POS_W-1:0] bit_pos;
  logic [FR_W-1:0]  frame_idx;
  logic             is_fbit;
  logic             fbit_now;
  logic             fbit_val;
  logic             next_bit;
  logic             data_q, fs_q, sf_q;
  logic             data_n, fs_n, sf_n;

  assign fbit_now = cfg_framed & is_fbit;
  assign step     = bit_en & ~fbit_now;
  assign adv      = bit_en & cfg_framed;

  ds1_pat_src #(.USER_W(USER_W)) u_src (
    .clk(clk), .rst_n(rst_n), .step(step), .sel(cfg_pat_sel),
    .user_word(cfg_user_word), .pat_bit(pat_bit)
  );

  ds1_frame_ctr u_frm (
    .clk(clk), .rst_n(rst_n), .adv(adv), .esf(cfg_esf),
    .bit_pos(bit_pos), .frame_idx(frame_idx), .is_fbit(is_fbit)
  );

  always_comb begin
    fbit_val = cfg_esf ? esf_fbit(frame_idx) : sf_fbit(frame_idx);
    if (cfg_fbit_inv && frame_idx == FR_W'(11)) fbit_val = ~fbit_val;
    next_bit = fbit_now ? fbit_val : pat_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      fs_q   <= 1'b0;
      sf_q   <= 1'b0;
    end else if (bit_en) begin
      data_q <= next_bit ^ cfg_tx_inv;
      fs_q   <= fbit_now;
      sf_q   <= fbit_now & (frame_idx == '0);
    end else begin
      fs_q <= 1'b0;
      sf_q <= 1'b0;
    end
  end

  // falling-edge launch stage
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_n <= 1'b0;
      fs_n   <= 1'b0;
      sf_n   <= 1'b0;
    end else begin
      data_n <= data_q;
      fs_n   <= fs_q;
      sf_n   <= sf_q;
    end
  end

  assign tx_data        = cfg_launch_rise ? data_q : data_n;
  assign tx_frame_start = cfg_launch_rise ? fs_q   : fs_n;
  assign tx_sf_start    = cfg_launch_rise ? sf_q   : sf_n;
endmodule

// File: rtl/ds1_tpgen_chk.sv
module ds1_tpgen_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          cfg_framed,
  input logic [2:0]    cfg_pat_sel,
  input logic          step,
  input logic          pat_bit,
  input logic [PW-1:0] bit_pos,
  input logic          data_q,
  input logic          fs_q,
  input logic          sf_q
);
  logic [4:0] zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      zrun <= '0;
    else if (cfg_pat_sel != 3'd2)    zrun <= '0;
    else if (step && pat_bit)        zrun <= '0;
    else if (step && zrun != 5'd31)  zrun <= zrun + 5'd1;
  end

  // R2: quasi-random source never yields 15 zeros in a row
  a_r2_qrss_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= 5'd14);

  // R7: idle clock holds data and clears markers
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(data_q) && !fs_q && !sf_q));

  // R8: position within a frame stays inside 193 bits
  a_r8_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= PW'(192));

  // R12: superframe marker only coincides with a frame marker
  a_r12_sf_in_fs: assert property (@(posedge clk) disable iff (!rst_n)
    sf_q |-> fs_q);

  // R12: no frame marker in unframed mode
  a_r12_unframed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !cfg_framed) |=> !fs_q);
endmodule

bind ds1_tpgen ds1_tpgen_chk #(.PW(ds1_tpg_pkg::POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_framed(cfg_framed),
  .cfg_pat_sel(cfg_pat_sel), .step(step), .pat_bit(pat_bit),
  .bit_pos(bit_pos), .data_q(data_q), .fs_q(fs_q), .sf_q(sf_q)
);

// File: tb/ds1_tpgen_tb.sv
`timescale 1ns/1ps
module ds1_tpgen_tb;
  localparam int L = 8200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic [2:0]  cfg_pat_sel = 3'd0;
  logic        cfg_tx_inv = 1'b0;
  logic        cfg_launch_rise = 1'b1;
  logic        cfg_framed = 1'b0;
  logic        cfg_esf = 1'b0;
  logic        cfg_fbit_inv = 1'b0;
  logic [31:0] cfg_user_word = '0;
  logic        tx_data, tx_frame_start, tx_sf_start;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit p15 [L];
  bit p20 [L];
  bit p23 [L];

  always #2 clk = ~clk;

  ds1_tpgen u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_pat_sel(cfg_pat_sel),
    .cfg_tx_inv(cfg_tx_inv), .cfg_launch_rise(cfg_launch_rise),
    .cfg_framed(cfg_framed), .cfg_esf(cfg_esf), .cfg_fbit_inv(cfg_fbit_inv),
    .cfg_user_word(cfg_user_word), .tx_data(tx_data),
    .tx_frame_start(tx_frame_start), .tx_sf_start(tx_sf_start)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit qrss(input int t);
    for (int k = 0; k < 15; k++) if (p20[t+k]) return p20[t];
    return 1'b1;
  endfunction

  function automatic bit payload(input int sel, input int t, input logic [31:0] w);
    case (sel)
      0: return p15[t];
      1: return p20[t];
      2: return qrss(t);
      3: return p23[t];
      4: return (t % 2) == 0;
      5: return 1'b1;
      6: return 1'b0;
      default: return w[31 - (t % 32)];
    endcase
  endfunction

  function automatic bit framing(input bit esf, input bit finv, input int fr);
    int n;
    bit v;
    n = fr + 1;
    if (!esf) begin
      if (n % 2 == 1) v = (((n - 1) / 2) % 2) == 0;
      else begin
        case (n / 2)
          3, 4, 5: v = 1'b1;
          default: v = 1'b0;
        endcase
      end
    end else if (n % 4 == 0) begin
      case (n / 4)
        3, 5, 6: v = 1'b1;
        default: v = 1'b0;
      endcase
    end else v = 1'b1;
    if (finv && n == 12) v = ~v;
    return v;
  endfunction

  task automatic run(input string tag, input int sel, input bit inv, input bit rise,
                     input bit framed, input bit esf, input bit finv,
                     input logic [31:0] w, input int n, input int en_div);
    int t, bp, fr;
    bit ed, efs, esfm, pd, pfs, psf, en;
    rst_n = 1'b0;
    bit_en = 1'b0;
    cfg_pat_sel = 3'(sel);
    cfg_tx_inv = inv;
    cfg_launch_rise = rise;
    cfg_framed = framed;
    cfg_esf = esf;
    cfg_fbit_inv = finv;
    cfg_user_word = w;
    @(posedge clk);
    @(posedge clk);
    #1;
    // R13: outputs are zero under reset
    check("R13 reset data", tx_data, 1'b0);
    check("R13 reset frame marker", tx_frame_start, 1'b0);
    check("R13 reset superframe marker", tx_sf_start, 1'b0);
    rst_n = 1'b1;
    t = 0; bp = 0; fr = 0;
    ed = 0; efs = 0; esfm = 0;
    for (int i = 0; i < n; i++) begin
      en = (en_div == 1) || ((i % en_div) != 0);
      bit_en = en;
      @(posedge clk);
      pd = ed; pfs = efs; psf = esfm;
      if (en) begin
        if (framed && bp == 0) begin
          ed = framing(esf, finv, fr) ^ inv;
          efs = 1'b1;
          esfm = (fr == 0);
        end else begin
          ed = payload(sel, t, w) ^ inv;
          t++;
          efs = 1'b0;
          esfm = 1'b0;
        end
        if (framed) begin
          bp++;
          if (bp == 193) begin
            bp = 0;
            fr = (fr + 1) % (esf ? 24 : 12);
          end
        end
      end else begin
        efs = 1'b0;
        esfm = 1'b0;
      end
      #1;
      check(tag, tx_data, rise ? ed : pd);
      check({tag, " frame marker"}, tx_frame_start, rise ? efs : pfs);
      check({tag, " superframe marker"}, tx_sf_start, rise ? esfm : psf);
    end
    bit_en = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < L; k++) begin
      p15[k] = (k < 15) ? 1'b1 : p15[k-15] ^ p15[k-14];
      p20[k] = (k < 20) ? 1'b1 : p20[k-20] ^ p20[k-3];
      p23[k] = (k < 23) ? 1'b1 : p23[k-23] ^ p23[k-18];
    end
    run("R1 prbs15",                  0, 0, 1, 0, 0, 0, 32'h0, 1500, 1);
    run("R1 prbs20",                  1, 0, 1, 0, 0, 0, 32'h0, 1500, 1);
    run("R1 prbs23",                  3, 0, 1, 0, 0, 0, 32'h0, 1500, 1);
    run("R2 qrss",                    2, 0, 1, 0, 0, 0, 32'h0, 3000, 1);
    run("R3 alternating",             4, 0, 1, 0, 0, 0, 32'h0, 100, 1);
    run("R3 all ones",                5, 0, 1, 0, 0, 0, 32'h0, 100, 1);
    run("R3 all zeros",               6, 0, 1, 0, 0, 0, 32'h0, 100, 1);
    run("R4 user word",               7, 0, 1, 0, 0, 0, 32'hA5C3_0F96, 200, 1);
    run("R7 user word gapped enable", 7, 0, 1, 0, 0, 0, 32'h8000_0001, 300, 3);
    run("R5 inverted prbs15",         0, 1, 1, 0, 0, 0, 32'h0, 300, 1);
    run("R6 falling launch prbs20",   1, 0, 0, 0, 0, 0, 32'h0, 300, 2);
    run("R6 falling launch framed",   5, 0, 0, 1, 0, 0, 32'h0, 600, 1);
    run("R9 R8 R12 sf framed prbs15", 0, 0, 1, 1, 0, 0, 32'h0, 2600, 1);
    run("R10 R12 esf framed ones",    5, 0, 1, 1, 1, 0, 32'h0, 4800, 1);
    run("R11 esf fbit invert user",   7, 0, 1, 1, 1, 1, 32'h1234_5678, 4800, 1);
    run("R11 R7 sf fbit invert zeros", 6, 1, 1, 1, 0, 1, 32'h0, 3300, 4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule